// File: doc/BRIEF.md
# Register-Typed Packed SIMD Adder

This block performs packed integer addition and subtraction on a 32-bit datapath where the lane format is not carried by the opcode. Instead, the register numbers of the destination and the two sources select the lane width and signedness, so a single add, subtract, halving-add or halving-subtract operation covers every packed format. The block takes the three 5-bit register indices, the two operand values already read from a register file, a 2-bit arithmetic mode and a 2-bit operation select. It returns the packed result, one saturation flag per lane, a flag for illegal register combinations and a flag that marks a write to the zero register as discarded.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream, one cycle after acceptance. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output slot is empty or is being drained in the same cycle. While a result is waiting and `out_ready` is low, the result and its flags stay frozen and no new request is taken. Register storage, predication and instruction decode lie outside this block.

Top module: `simd_regtyped_adder`

## Requirements
- R1: Register index decoding sets the lane format. Indices 2 to 7 are four signed 8-bit lanes. Indices 8 to 15 are four unsigned 8-bit lanes. Indices 16 to 23 are two signed 16-bit lanes. Indices 24 to 29 are two unsigned 16-bit lanes. Indices 30 and 31 are one signed 32-bit lane. Lane i occupies bits [i*W+W-1 : i*W].
- R2: The format is taken from the first nonzero index in the order destination, source A, source B. When all three indices are 0, the format is one signed 32-bit lane.
- R3: The operation select encodes add as 00, subtract as 01, halving add as 10 and halving subtract as 11. With mode 00, add and subtract wrap modulo 2^W in each lane and clear every saturation flag.
- R4: With mode 01, add and subtract clamp each lane to its signed or unsigned range. Saturation flag bit i is set exactly when lane i was clamped. For 16-bit lanes this is flag bit 0 or 1, for the 32-bit lane it is bit 0, and all unused flag bits are 0.
- R5: Halving add and halving subtract return bits [W:1] of the exact (W+1)-bit sum or difference. This is an arithmetic shift for signed lanes and a logical shift for unsigned lanes. Modes 00 and 01 give the same result, and no saturation flag is ever set.
- R6: A source index of 0 reads as zero, whatever value is presented on the matching operand input.
- R7: A destination index of 0 sets `discarded`, and the computed result is still delivered.
- R8: The request is illegal if any of the following holds: any index equals 1; two nonzero indices fall in different width groups (2–15, 16–29, 30–31); the mode is 10 or 11; or the request is saturating or halving and its nonzero indices mix signed and unsigned banks. Wrapping add and subtract in mode 00 accept mixed signedness. An illegal request drives `illegal` high, the result to zero and all saturation flags to zero.
- R9: A request accepted at one edge appears at the output after the next edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the output and its flags hold steady.
- R10: During and after reset, `out_valid` is low until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| dst_idx | input | 5 | Destination register index |
| srca_idx | input | 5 | Source A register index |
| srcb_idx | input | 5 | Source B register index |
| opa | input | 32 | Source A value |
| opb | input | 32 | Source B value |
| mode | input | 2 | 00 wrap, 01 saturate, others illegal |
| op | input | 2 | 00 add, 01 sub, 10 halving add, 11 halving sub |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| res | output | 32 | Packed result |
| sat_flags | output | 4 | Per-lane clamp indicators |
| illegal | output | 1 | Illegal register or mode combination |
| discarded | output | 1 | Destination was register 0 |

## Verification
Directed requests place the same operand bit patterns in each of the five banks, so that wrap, clamp and halving outcomes differ by format. Examples are 127+1 in a signed byte lane against an unsigned byte lane, 0−1 unsigned, and the most negative 16-bit value doubled. Other requests hold the destination or sources at index 0 to separate the format-priority rule from operand zeroing, and combine index 1, mixed width groups and mixed signedness with each operation to separate legal wrapping cases from illegal exact ones. A long pseudo-random stream over all indices, modes and operations then runs first with the consumer always ready and then under random back-pressure, to test that results stay in order and remain stable while stalled.

// File: rtl/simd_regtype_pkg.sv
package simd_regtype_pkg;

  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  // first index of each bank; decoding order is part of the behaviour
  localparam int BANK_S8_LO  = 2;
  localparam int BANK_U8_LO  = 8;
  localparam int BANK_S16_LO = 16;
  localparam int BANK_U16_LO = 24;
  localparam int BANK_S32_LO = 30;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_HADD = 2'b10,
    OP_HSUB = 2'b11
  } arith_op_e;

  typedef enum logic [1:0] {
    GRP_NONE = 2'd0,
    GRP_BYTE = 2'd1,
    GRP_HALF = 2'd2,
    GRP_WORD = 2'd3
  } width_grp_e;

  typedef struct packed {
    logic       is_zero;
    logic       is_mask;
    width_grp_e grp;
    logic       is_signed;
  } reg_class_t;

endpackage

// File: rtl/simd_bank_decode.sv
module simd_bank_decode
  import simd_regtype_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] idx,
  output reg_class_t       cls
);

  always_comb begin
    cls = '{is_zero: 1'b0, is_mask: 1'b0, grp: GRP_NONE, is_signed: 1'b0};
    if (idx == '0) begin
      cls.is_zero = 1'b1;
    end else if (idx < IDX_W'(BANK_S8_LO)) begin
      cls.is_mask = 1'b1;
    end else if (idx < IDX_W'(BANK_U8_LO)) begin
      cls.grp       = GRP_BYTE;
      cls.is_signed = 1'b1;
    end else if (idx < IDX_W'(BANK_S16_LO)) begin
      cls.grp       = GRP_BYTE;
    end else if (idx < IDX_W'(BANK_U16_LO)) begin
      cls.grp       = GRP_HALF;
      cls.is_signed = 1'b1;
    end else if (idx < IDX_W'(BANK_S32_LO)) begin
      cls.grp       = GRP_HALF;
    end else begin
      cls.grp       = GRP_WORD;
      cls.is_signed = 1'b1;
    end
  end

endmodule

// File: rtl/simd_format_ctrl.sv
module simd_format_ctrl
  import simd_regtype_pkg::*;
(
  input  reg_class_t cls_d,
  input  reg_class_t cls_a,
  input  reg_class_t cls_b,
  input  logic [1:0] mode,
  input  logic [1:0] op,
  output width_grp_e grp,
  output logic       is_signed,
  output logic       subtract,
  output logic       halve,
  output logic       saturate,
  output logic       illegal
);

  localparam int NREG = 3;

  reg_class_t cls [NREG];
  logic       exact_op;
  logic       grp_clash;
  logic       sign_clash;
  logic       any_mask;

  assign cls[0] = cls_d;
  assign cls[1] = cls_a;
  assign cls[2] = cls_b;

  assign subtract = op[0];
  assign halve    = op[1];
  assign saturate = (mode == 2'b01) && !op[1];
  assign exact_op = op[1] || mode[0];

  // primary format: first data-bearing register in destination, A, B order
  always_comb begin
    grp       = GRP_WORD;
    is_signed = 1'b1;
    for (int k = NREG - 1; k >= 0; k--) begin
      if (cls[k].grp != GRP_NONE) begin
        grp       = cls[k].grp;
        is_signed = cls[k].is_signed;
      end
    end
  end

  always_comb begin
    grp_clash  = 1'b0;
    sign_clash = 1'b0;
    any_mask   = 1'b0;
    for (int k = 0; k < NREG; k++) begin
      any_mask = any_mask | cls[k].is_mask;
      if (cls[k].grp != GRP_NONE) begin
        grp_clash  = grp_clash  | (cls[k].grp != grp);
        sign_clash = sign_clash | (cls[k].is_signed != is_signed);
      end
    end
  end

  assign illegal = any_mask || grp_clash || mode[1] || (sign_clash && exact_op);

endmodule

// File: rtl/simd_lane_arith.sv
module simd_lane_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         is_signed,
  input  logic         subtract,
  input  logic         saturate,
  input  logic         halve,
  output logic [W-1:0] res,
  output logic         clamped
);

  logic [W:0]   ext_a;
  logic [W:0]   ext_b;
  logic [W:0]   full;
  logic         overflow;
  logic [W-1:0] limit;

  assign ext_a = {is_signed & a[W-1], a};
  assign ext_b = {is_signed & b[W-1], b};
  assign full  = subtract ? (ext_a - ext_b) : (ext_a + ext_b);

  // guard bit disagreeing with the lane sign bit means a signed overflow;
  // a set guard bit on an unsigned lane is a carry or a borrow
  assign overflow = is_signed ? (full[W] ^ full[W-1]) : full[W];

  always_comb begin
    if (is_signed)
      limit = full[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    else
      limit = subtract ? '0 : '1;
  end

  always_comb begin
    clamped = 1'b0;
    if (halve) begin
      res = full[W:1];
    end else if (saturate && overflow) begin
      res     = limit;
      clamped = 1'b1;
    end else begin
      res = full[W-1:0];
    end
  end

endmodule

// File: rtl/simd_regtyped_adder.sv
module simd_regtyped_adder
  import simd_regtype_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [IDX_W-1:0]         dst_idx,
  input  logic [IDX_W-1:0]         srca_idx,
  input  logic [IDX_W-1:0]         srcb_idx,
  input  logic [DATA_W-1:0]        opa,
  input  logic [DATA_W-1:0]        opb,
  input  logic [1:0]               mode,
  input  logic [1:0]               op,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [DATA_W-1:0]        res,
  output logic [DATA_W/BYTE_W-1:0] sat_flags,
  output logic                     illegal,
  output logic                     discarded
);

  localparam int N_BYTE = DATA_W / BYTE_W;
  localparam int N_HALF = DATA_W / HALF_W;
  localparam int FLAG_W = N_BYTE;

  reg_class_t  cls_d, cls_a, cls_b;
  width_grp_e  fmt_grp;
  logic        fmt_signed, do_sub, do_half, do_sat, bad_combo;
  logic [DATA_W-1:0] a_eff, b_eff;

  logic [DATA_W-1:0] r_byte, r_half, r_word;
  logic [N_BYTE-1:0] c_byte;
  logic [N_HALF-1:0] c_half;
  logic              c_word;

  logic [DATA_W-1:0] res_nxt;
  logic [FLAG_W-1:0] flag_nxt;

  simd_bank_decode #(.IDX_W(IDX_W)) u_dec_d (.idx(dst_idx),  .cls(cls_d));
  simd_bank_decode #(.IDX_W(IDX_W)) u_dec_a (.idx(srca_idx), .cls(cls_a));
  simd_bank_decode #(.IDX_W(IDX_W)) u_dec_b (.idx(srcb_idx), .cls(cls_b));

  simd_format_ctrl u_ctrl (
    .cls_d    (cls_d),
    .cls_a    (cls_a),
    .cls_b    (cls_b),
    .mode     (mode),
    .op       (op),
    .grp      (fmt_grp),
    .is_signed(fmt_signed),
    .subtract (do_sub),
    .halve    (do_half),
    .saturate (do_sat),
    .illegal  (bad_combo)
  );

  assign a_eff = cls_a.is_zero ? '0 : opa;
  assign b_eff = cls_b.is_zero ? '0 : opb;

  for (genvar i = 0; i < N_BYTE; i++) begin : g_byte
    simd_lane_arith #(.W(BYTE_W)) u_lane (
      .a        (a_eff[i*BYTE_W +: BYTE_W]),
      .b        (b_eff[i*BYTE_W +: BYTE_W]),
      .is_signed(fmt_signed),
      .subtract (do_sub),
      .saturate (do_sat),
      .halve    (do_half),
      .res      (r_byte[i*BYTE_W +: BYTE_W]),
      .clamped  (c_byte[i])
    );
  end

  for (genvar i = 0; i < N_HALF; i++) begin : g_half
    simd_lane_arith #(.W(HALF_W)) u_lane (
      .a        (a_eff[i*HALF_W +: HALF_W]),
      .b        (b_eff[i*HALF_W +: HALF_W]),
      .is_signed(fmt_signed),
      .subtract (do_sub),
      .saturate (do_sat),
      .halve    (do_half),
      .res      (r_half[i*HALF_W +: HALF_W]),
      .clamped  (c_half[i])
    );
  end

  simd_lane_arith #(.W(DATA_W)) u_word (
    .a        (a_eff),
    .b        (b_eff),
    .is_signed(fmt_signed),
    .subtract (do_sub),
    .saturate (do_sat),
    .halve    (do_half),
    .res      (r_word),
    .clamped  (c_word)
  );

  always_comb begin
    case (fmt_grp)
      GRP_BYTE: begin
        res_nxt  = r_byte;
        flag_nxt = c_byte;
      end
      GRP_HALF: begin
        res_nxt  = r_half;
        flag_nxt = FLAG_W'(c_half);
      end
      default: begin
        res_nxt  = r_word;
        flag_nxt = FLAG_W'(c_word);
      end
    endcase
    if (bad_combo) begin
      res_nxt  = '0;
      flag_nxt = '0;
    end
  end

  // single output slot: accept when empty or being drained
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res       <= '0;
      sat_flags <= '0;
      illegal   <= 1'b0;
      discarded <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      res       <= res_nxt;
      sat_flags <= flag_nxt;
      illegal   <= bad_combo;
      discarded <= cls_d.is_zero;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/simd_regtyped_adder_chk.sv
module simd_regtyped_adder_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  parameter int FLAG_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [IDX_W-1:0]  dst_idx,
  input logic [IDX_W-1:0]  srca_idx,
  input logic [IDX_W-1:0]  srcb_idx,
  input logic [1:0]        mode,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] res,
  input logic [FLAG_W-1:0] sat_flags,
  input logic              illegal,
  input logic              discarded
);

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res) && $stable(sat_flags)
                                && $stable(illegal) && $stable(discarded));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_illegal_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && illegal |-> res == '0 && sat_flags == '0);

  p_mask_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (dst_idx == IDX_W'(1) || srca_idx == IDX_W'(1) || srcb_idx == IDX_W'(1))
    |=> illegal);

  p_wrap_noflag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && mode == 2'b00 |=> sat_flags == '0);

  p_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> discarded == ($past(dst_idx) == '0));

endmodule

bind simd_regtyped_adder simd_regtyped_adder_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .FLAG_W(DATA_W/8)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .dst_idx(dst_idx), .srca_idx(srca_idx), .srcb_idx(srcb_idx), .mode(mode),
  .out_valid(out_valid), .out_ready(out_ready), .res(res), .sat_flags(sat_flags),
  .illegal(illegal), .discarded(discarded)
);

// File: tb/simd_regtyped_adder_test.sv
`timescale 1ns/100ps
module simd_regtyped_adder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  dst_idx = '0, srca_idx = '0, srcb_idx = '0;
  logic [31:0] opa = '0, opb = '0;
  logic [1:0]  mode = '0, op = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] res;
  logic [3:0]  sat_flags;
  logic        illegal, discarded;

  int n_tests = 0;
  int n_fail  = 0;
  bit bp_en   = 1'b0;
  bit done    = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic [3:0]  sat;
    logic        ill;
    logic        disc;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  always #2 clk = ~clk;

  simd_regtyped_adder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .dst_idx(dst_idx), .srca_idx(srca_idx), .srcb_idx(srcb_idx),
    .opa(opa), .opb(opb), .mode(mode), .op(op),
    .out_valid(out_valid), .out_ready(out_ready), .res(res),
    .sat_flags(sat_flags), .illegal(illegal), .discarded(discarded)
  );

  // bank width per index: 0 -> none, -1 -> mask, otherwise lane bits
  function automatic void bank_of(input logic [4:0] i, output int w, output bit sg);
    sg = 1'b0;
    if (i == 0)       w = 0;
    else if (i == 1)  w = -1;
    else if (i <= 7)  begin w = 8;  sg = 1'b1; end
    else if (i <= 15) w = 8;
    else if (i <= 23) begin w = 16; sg = 1'b1; end
    else if (i <= 29) w = 16;
    else              begin w = 32; sg = 1'b1; end
  endfunction

  function automatic exp_t model(input logic [4:0] d, input logic [4:0] sa, input logic [4:0] sb,
                                 input logic [31:0] a, input logic [31:0] b,
                                 input logic [1:0] md, input logic [1:0] o);
    exp_t e;
    int   wv[3];
    bit   sv[3];
    int   w;
    bit   sg;
    longint acc, m, av, bv;
    bank_of(d,  wv[0], sv[0]);
    bank_of(sa, wv[1], sv[1]);
    bank_of(sb, wv[2], sv[2]);
    e.ill = md[1];
    w = 32; sg = 1'b1;
    for (int k = 2; k >= 0; k--) if (wv[k] > 0) begin w = wv[k]; sg = sv[k]; end
    for (int k = 0; k < 3; k++) begin
      if (wv[k] < 0) e.ill = 1'b1;
      if (wv[k] > 0 && wv[k] != w) e.ill = 1'b1;
      if (wv[k] > 0 && sv[k] != sg && (o[1] || md[0])) e.ill = 1'b1;
    end
    e.disc = (d == 0);
    e.sat  = '0;
    acc    = 0;
    av = (sa == 0) ? 0 : longint'(a);
    bv = (sb == 0) ? 0 : longint'(b);
    m  = (longint'(1) << w) - 1;
    if (!e.ill) begin
      for (int i = 0; i < 32 / w; i++) begin
        longint x, y, f, lo, hi;
        x = (av >> (i * w)) & m;
        y = (bv >> (i * w)) & m;
        if (sg && x >= (longint'(1) << (w - 1))) x = x - (longint'(1) << w);
        if (sg && y >= (longint'(1) << (w - 1))) y = y - (longint'(1) << w);
        f  = o[0] ? (x - y) : (x + y);
        lo = sg ? -(longint'(1) << (w - 1)) : 0;
        hi = sg ? (longint'(1) << (w - 1)) - 1 : m;
        if (o[1]) f = f >>> 1;
        else if (md[0]) begin
          if (f > hi) begin f = hi; e.sat[i] = 1'b1; end
          if (f < lo) begin f = lo; e.sat[i] = 1'b1; end
        end
        acc = acc | ((f & m) << (i * w));
      end
    end
    e.res = acc[31:0];
    return e;
  endfunction

  task automatic send(input logic [4:0] d, input logic [4:0] sa, input logic [4:0] sb,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic [1:0] md, input logic [1:0] o, input string tag);
    exp_t e;
    @(negedge clk);
    dst_idx = d; srca_idx = sa; srcb_idx = sb;
    opa = a; opb = b; mode = md; op = o;
    in_valid = 1'b1;
    #0.5;
    while (!in_ready) begin
      @(negedge clk);
      #0.5;
    end
    e = model(d, sa, sb, a, b, md, o);
    e.tag = tag;
    sb_q.push_back(e);
    @(posedge clk);
    #0.2;
    in_valid = 1'b0;
  endtask

  task automatic check1(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: compares each handed-over result with the scoreboard head
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (sb_q.size() == 0) begin
          check1(1'b0, "R9", "unexpected output", res, 32'h0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check1(res == e.res, e.tag, "res", res, e.res);
          check1(sat_flags == e.sat, e.tag, "sat_flags", {28'h0, sat_flags}, {28'h0, e.sat});
          check1(illegal == e.ill, e.tag, "illegal", {31'h0, illegal}, {31'h0, e.ill});
          check1(discarded == e.disc, e.tag, "discarded", {31'h0, discarded}, {31'h0, e.disc});
        end
      end
    end
  end

  // consumer back-pressure
  initial begin
    forever begin
      @(posedge clk);
      #0.3;
      out_ready = bp_en ? 1'($urandom_range(1, 0)) : 1'b1;
    end
  end

  // watchdog
  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: no output while in reset
    check1(out_valid == 1'b0, "R10", "out_valid in reset", {31'h0, out_valid}, 32'h0);
    check1(in_ready == 1'b1, "R9", "in_ready in reset", {31'h0, in_ready}, 32'h1);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check1(out_valid == 1'b0, "R10", "out_valid after reset", {31'h0, out_valid}, 32'h0);

    // R1: each bank with identical operand bits
    send(5'd2,  5'd3,  5'd4,  32'h7F80_01FF, 32'h0180_FF01, 2'b00, 2'b00, "R1");
    send(5'd9,  5'd10, 5'd11, 32'h7F80_01FF, 32'h0180_FF01, 2'b01, 2'b00, "R1");
    send(5'd17, 5'd18, 5'd19, 32'h7FFF_8000, 32'h0001_FFFF, 2'b01, 2'b00, "R1");
    send(5'd25, 5'd26, 5'd27, 32'h7FFF_8000, 32'h0001_FFFF, 2'b01, 2'b00, "R1");
    send(5'd30, 5'd31, 5'd30, 32'h7FFF_FFFF, 32'h0000_0001, 2'b01, 2'b00, "R1");
    // R2: destination 0 leaves the format to the sources
    send(5'd0,  5'd9,  5'd10, 32'hFF00_0010, 32'h0101_0020, 2'b01, 2'b01, "R2");
    send(5'd0,  5'd0,  5'd20, 32'hFFFF_FFFF, 32'h8000_8000, 2'b00, 2'b10, "R2");
    send(5'd0,  5'd0,  5'd0,  32'h1234_5678, 32'h0000_0001, 2'b01, 2'b01, "R2");
    // R3: wrapping forms, including mixed signedness within a width group
    send(5'd16, 5'd17, 5'd18, 32'h0000_8000, 32'h0001_0001, 2'b00, 2'b01, "R3");
    send(5'd2,  5'd8,  5'd3,  32'hFFFF_FFFF, 32'h0101_0101, 2'b00, 2'b00, "R3");
    send(5'd24, 5'd16, 5'd29, 32'h0000_FFFF, 32'h0001_0001, 2'b00, 2'b01, "R3");
    // R4: clamps at both ends
    send(5'd5,  5'd6,  5'd7,  32'h807F_7F80, 32'h0101_FFFF, 2'b01, 2'b00, "R4");
    send(5'd12, 5'd13, 5'd14, 32'h0000_0510, 32'h0102_0320, 2'b01, 2'b01, "R4");
    send(5'd20, 5'd21, 5'd22, 32'h8000_7FFF, 32'h0001_FFFF, 2'b01, 2'b01, "R4");
    send(5'd31, 5'd30, 5'd31, 32'h8000_0000, 32'h0000_0001, 2'b01, 2'b01, "R4");
    // R5: halving in both modes and both signedness
    send(5'd8,  5'd9,  5'd10, 32'hFF10_0003, 32'hFF20_0001, 2'b00, 2'b11, "R5");
    send(5'd16, 5'd17, 5'd18, 32'h8000_8000, 32'h8000_0001, 2'b01, 2'b10, "R5");
    send(5'd3,  5'd4,  5'd5,  32'h7F80_7F01, 32'h7F80_80FF, 2'b00, 2'b10, "R5");
    send(5'd30, 5'd30, 5'd31, 32'h8000_0000, 32'h7FFF_FFFF, 2'b01, 2'b11, "R5");
    // R6: source index 0 ignores the operand bus
    send(5'd8,  5'd9,  5'd0,  32'h1122_3344, 32'hFFFF_FFFF, 2'b00, 2'b00, "R6");
    send(5'd16, 5'd0,  5'd17, 32'hFFFF_FFFF, 32'h0001_0002, 2'b01, 2'b01, "R6");
    // R7: destination 0 discards but still shows the result
    send(5'd0,  5'd2,  5'd3,  32'h0102_0304, 32'h1010_1010, 2'b00, 2'b00, "R7");
    // R8: illegal combinations
    send(5'd2,  5'd1,  5'd3,  32'h0102_0304, 32'h0506_0708, 2'b00, 2'b00, "R8");
    send(5'd1,  5'd2,  5'd3,  32'h0102_0304, 32'h0506_0708, 2'b00, 2'b00, "R8");
    send(5'd2,  5'd16, 5'd3,  32'h0102_0304, 32'h0506_0708, 2'b00, 2'b00, "R8");
    send(5'd16, 5'd17, 5'd30, 32'h0102_0304, 32'h0506_0708, 2'b00, 2'b00, "R8");
    send(5'd2,  5'd3,  5'd4,  32'h0102_0304, 32'h0506_0708, 2'b10, 2'b00, "R8");
    send(5'd2,  5'd8,  5'd3,  32'h7F7F_7F7F, 32'h0101_0101, 2'b01, 2'b00, "R8");
    send(5'd24, 5'd16, 5'd25, 32'h0001_0001, 32'h0001_0001, 2'b00, 2'b10, "R8");

    // R1: pseudo-random stream, consumer always ready
    for (int n = 0; n < 300; n++) begin
      send(5'($urandom), 5'($urandom), 5'($urandom), $urandom, $urandom,
           2'($urandom_range(2, 0)), 2'($urandom), "R1");
    end

    // R9: the same kind of stream under random back-pressure
    bp_en = 1'b1;
    for (int n = 0; n < 300; n++) begin
      send(5'($urandom_range(31, 2)), 5'($urandom_range(31, 0)), 5'($urandom_range(31, 0)),
           $urandom, $urandom, 2'($urandom_range(1, 0)), 2'($urandom), "R9");
    end
    bp_en = 1'b0;

    repeat (20) @(posedge clk);
    #1;
    check1(sb_q.size() == 0, "R9", "results outstanding", 32'(sb_q.size()), 32'h0);
    check1(out_valid == 1'b0, "R9", "out_valid after drain", {31'h0, out_valid}, 32'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule